// File: doc/BRIEF.md
# Rate-Sensor Sample Packing FIFO

This block collects samples from a three-axis rate sensor into a byte-wide first-in first-out store. Each sample consists of up to four 16-bit words: temperature, X rate, Y rate and Z rate. On every sample strobe, the words chosen by a capture-select byte are serialized into the store one byte per clock. The sequence is fixed: temperature first, then X, then Y, then Z, with the most significant byte of each word first. A host removes bytes through one read port, one byte per request. It watches a 16-bit fill count to learn how much is waiting.

A footer mode supports a host that must never drain the store completely. Once the host has taken at least one byte since the last clear, every later sample is preceded by two zero bytes. A host that always reads ten bytes per sample (footer plus one full sample) therefore leaves two bytes behind each time. The store holds 512 bytes. When the count reaches that value, the overflow flag rises and stays high until the store is cleared. Any bytes that arrive while the store is full are discarded.

A clear pulse empties the store and drops a sample still being serialized. It also forgets the footer state and lowers the overflow flag. An enable input gates capture only; reads work whether capture is enabled or not.

Top module: `gyro_sample_fifo`

## Requirements
- R1: After rst_n is released, fill_count is 0, ovf_flag is 0 and rd_data is 0.
- R2: In cap_en, bit 7 selects temperature, bit 6 selects X, bit 5 selects Y and bit 4 selects Z. Each selected word adds 2 bytes to the store. Bits 3 to 1 have no effect on what is stored.
- R3: The bytes of one sample are stored in this sequence: temperature, X, Y, Z (skipping unselected words). Each word is stored high byte first.
- R4: A rd_req pulse while fill_count is nonzero has two effects. On the following cycle, rd_data shows the oldest stored byte. At the same time, fill_count drops by one (less any byte written in that cycle).
- R5: A rd_req pulse while fill_count is 0 sets rd_data to 0x00 and leaves fill_count unchanged.
- R6: Footer mode is selected by cap_en bit 0. While it is set, and after at least one byte has been read since the last clear, every captured sample is preceded by two 0x00 bytes. Samples captured before that first read carry no footer. With bit 0 clear, no footer is ever added.
- R7: fill_count never exceeds 512. Bytes that arrive while the store holds 512 bytes are discarded.
- R8: ovf_flag rises on the cycle fill_count reaches 512. It stays high, even after reads, until a clear or a reset.
- R9: A fifo_reset pulse has the following effects on the next cycle: fill_count is 0 and ovf_flag is 0, any sample still being serialized is dropped, and the footer state is forgotten.
- R10: While fifo_enable is 0, sample strobes store nothing, and reads still operate.
- R11: A strobe that arrives while the previous sample is still being serialized is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_enable | input | 1 | Allows capture of new samples |
| fifo_reset | input | 1 | Single-cycle clear of the store |
| cap_en | input | 8 | Capture select: 7 temp, 6 X, 5 Y, 4 Z, 0 footer mode |
| sample_strobe | input | 1 | New sample words are valid |
| temp_word | input | 16 | Temperature sample |
| x_word | input | 16 | X-axis rate sample |
| y_word | input | 16 | Y-axis rate sample |
| z_word | input | 16 | Z-axis rate sample |
| rd_req | input | 1 | Pop one byte |
| rd_data | output | 8 | Byte returned for the previous rd_req |
| fill_count | output | 16 | Stored byte count; bits 15:8 form the high byte |
| ovf_flag | output | 1 | Sticky overflow status |

## Verification
Capture is exercised with a set of select patterns: all four words, each single word, pairs that skip a word, no words, and patterns with the auxiliary bits set. These patterns separate a wrong word sequence, a swapped byte order and a miscounted length. Each of them also shows whether bits 3 to 1 leak into the length. Footer behaviour is checked in three situations: a sample captured before any read, one captured after a read, and one captured after a clear. These distinguish a footer that is armed too early, one that is never armed, and one that survives a clear. Filling with 64 full samples and then one more tests several points: that the count stops exactly at 512, that the flag rises with it, and that the flag survives a read.

// File: rtl/gyro_fifo_pkg.sv
package gyro_fifo_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int NUM_CH = 4;
  localparam int SLOTS  = NUM_CH + 1;          // data words plus footer
  localparam int BUF_W  = WORD_W * SLOTS;
  localparam int LEFT_W = $clog2(2 * SLOTS + 1);
  localparam int CNT_W  = 16;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/sfifo_packer.sv
module sfifo_packer
  import gyro_fifo_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          enable,
  input  logic                          strobe,
  input  logic [NUM_CH-1:0][WORD_W-1:0] words,   // index 0 is temperature
  input  logic [NUM_CH-1:0]             ch_en,   // msb selects temperature
  input  logic                          add_footer,
  output logic                          wr_en,
  output byte_t                         wr_byte
);
  logic [BUF_W-1:0]  sh_q, sh_d, pack;
  logic [LEFT_W-1:0] left_q, left_d, nbytes;
  logic              accept;

  always_comb begin
    logic [BUF_W-1:0] acc;
    int k;
    acc = '0;
    k   = 0;
    if (add_footer && (ch_en != '0)) begin
      acc = {acc[BUF_W-WORD_W-1:0], {WORD_W{1'b0}}};
      k   = k + 1;
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_en[NUM_CH-1-i]) begin
        acc = {acc[BUF_W-WORD_W-1:0], words[i]};
        k   = k + 1;
      end
    end
    pack   = acc << (WORD_W * (SLOTS - k));
    nbytes = LEFT_W'(2 * k);
  end

  assign accept = enable && strobe && (left_q == '0) && (ch_en != '0);

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (clr) begin
      left_d = '0;
    end else if (accept) begin
      sh_d   = pack;
      left_d = nbytes;
    end else if (left_q != '0) begin
      sh_d   = sh_q << BYTE_W;
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  assign wr_en   = (left_q != '0) && !clr;
  assign wr_byte = sh_q[BUF_W-1 -: BYTE_W];
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store
  import gyro_fifo_pkg::*;
#(
  parameter  int DEPTH = 512,
  localparam int AW    = $clog2(DEPTH)
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        wr_en,
  input  byte_t       wr_byte,
  input  logic        rd_req,
  input  logic        footer_mode,
  output byte_t       rd_data,
  output logic [AW:0] count,
  output logic        ovf,
  output logic        armed
);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  byte_t         mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          ovf_q, ovf_d, arm_q, arm_d;
  byte_t         rdat_q, rdat_d;
  logic          push_ok, pop_ok;

  assign push_ok = wr_en && (cnt_q != FULL);
  assign pop_ok  = rd_req && (cnt_q != '0);

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    arm_d  = arm_q;
    rdat_d = rdat_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
      ovf_d  = 1'b0;
      arm_d  = 1'b0;
      rdat_d = '0;
    end else begin
      if (push_ok) wptr_d = wptr_q + 1'b1;
      if (pop_ok)  rptr_d = rptr_q + 1'b1;
      cnt_d = cnt_q + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
      ovf_d = ovf_q || (cnt_d == FULL);
      arm_d = arm_q || (pop_ok && footer_mode);
      if (rd_req) rdat_d = pop_ok ? mem[rptr_q] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wptr_q] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      arm_q  <= 1'b0;
      rdat_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
      arm_q  <= arm_d;
      rdat_q <= rdat_d;
    end
  end

  assign rd_data = rdat_q;
  assign count   = cnt_q;
  assign ovf     = ovf_q;
  assign armed   = arm_q;
endmodule

// File: rtl/gyro_sample_fifo.sv
module gyro_sample_fifo
  import gyro_fifo_pkg::*;
#(
  parameter int DEPTH = 512
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_enable,
  input  logic             fifo_reset,
  input  logic [7:0]       cap_en,
  input  logic             sample_strobe,
  input  logic [15:0]      temp_word,
  input  logic [15:0]      x_word,
  input  logic [15:0]      y_word,
  input  logic [15:0]      z_word,
  input  logic             rd_req,
  output logic [7:0]       rd_data,
  output logic [CNT_W-1:0] fill_count,
  output logic             ovf_flag
);
  localparam int AW = $clog2(DEPTH);

  logic                          wr_en, armed;
  byte_t                         wr_byte;
  logic [AW:0]                   count;
  logic [NUM_CH-1:0][WORD_W-1:0] words;
  logic                          unused_aux;

  assign words      = {z_word, y_word, x_word, temp_word};
  assign unused_aux = ^cap_en[3:1];   // auxiliary-axis selects are not captured

  sfifo_packer u_packer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (fifo_reset),
    .enable     (fifo_enable),
    .strobe     (sample_strobe),
    .words      (words),
    .ch_en      (cap_en[7:4]),
    .add_footer (armed && cap_en[0]),
    .wr_en      (wr_en),
    .wr_byte    (wr_byte)
  );

  sfifo_store #(.DEPTH(DEPTH)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (fifo_reset),
    .wr_en       (wr_en),
    .wr_byte     (wr_byte),
    .rd_req      (rd_req),
    .footer_mode (cap_en[0]),
    .rd_data     (rd_data),
    .count       (count),
    .ovf         (ovf_flag),
    .armed       (armed)
  );

  assign fill_count = {{(CNT_W-AW-1){1'b0}}, count};
endmodule

// File: rtl/gyro_sample_fifo_chk.sv
module gyro_sample_fifo_chk #(
  parameter int DEPTH = 512
)(
  input logic        clk,
  input logic        rst_n,
  input logic        fifo_reset,
  input logic        rd_req,
  input logic [7:0]  rd_data,
  input logic [15:0] fill_count,
  input logic        ovf_flag
);
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= 16'(DEPTH));

  assert_full_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == 16'(DEPTH)) |-> ovf_flag);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !fifo_reset) |=> ovf_flag);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_reset |=> (fill_count == 16'd0) && !ovf_flag);

  assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !fifo_reset && fill_count == 16'd0) |=>
      (rd_data == 8'h00) && (fill_count <= 16'd1));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_reset |=> (fill_count <= $past(fill_count) + 16'd1) &&
                    (fill_count + 16'd1 >= $past(fill_count)));
endmodule

bind gyro_sample_fifo gyro_sample_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_reset (fifo_reset),
  .rd_req     (rd_req),
  .rd_data    (rd_data),
  .fill_count (fill_count),
  .ovf_flag   (ovf_flag)
);

// File: tb/gyro_sample_fifo_tb_top.sv
`timescale 1ns/1ps
module gyro_sample_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_enable = 1'b0, fifo_reset = 1'b0, sample_strobe = 1'b0, rd_req = 1'b0;
  logic [7:0]  cap_en = 8'h00;
  logic [15:0] temp_word = '0, x_word = '0, y_word = '0, z_word = '0;
  logic [7:0]  rd_data;
  logic [15:0] fill_count;
  logic        ovf_flag;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_b [0:15];
  int exp_n;

  always #2.5 clk = ~clk;

  gyro_sample_fifo dut_i (.*);

  // {cap_en, expected byte count after one capture}
  localparam logic [15:0] VEC [8] = '{
    {8'hF0, 8'd8}, {8'h80, 8'd2}, {8'h40, 8'd2}, {8'h30, 8'd4},
    {8'hA0, 8'd4}, {8'h0E, 8'd0}, {8'hFE, 8'd8}, {8'h51, 8'd4}};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sample(logic [15:0] t, logic [15:0] x, logic [15:0] y, logic [15:0] z);
    @(negedge clk);
    temp_word = t; x_word = x; y_word = y; z_word = z;
    sample_strobe = 1'b1;
    @(negedge clk);
    sample_strobe = 1'b0;
    cycles(12);
  endtask

  task automatic read_byte(output logic [7:0] b);
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    b = rd_data;
  endtask

  task automatic clear();
    @(negedge clk);
    fifo_reset = 1'b1;
    @(negedge clk);
    fifo_reset = 1'b0;
  endtask

  // Expected bytes per R3: temp, X, Y, Z, high byte first; footer first if asked
  task automatic build(logic [7:0] en, bit ftr, logic [15:0] t, logic [15:0] x,
                       logic [15:0] y, logic [15:0] z);
    logic [15:0] w [4];
    w[0] = t; w[1] = x; w[2] = y; w[3] = z;
    exp_n = 0;
    if (ftr && en[7:4] != 0) begin
      exp_b[0] = 8'h00; exp_b[1] = 8'h00; exp_n = 2;
    end
    for (int i = 0; i < 4; i++) begin
      if (en[7-i]) begin
        exp_b[exp_n] = w[i][15:8]; exp_b[exp_n+1] = w[i][7:0];
        exp_n += 2;
      end
    end
  endtask

  task automatic drain_expect(string req, int first);
    logic [7:0] b;
    for (int i = first; i < exp_n; i++) begin
      read_byte(b);
      chk(req, b, exp_b[i]);
    end
  endtask

  initial begin
    logic [7:0] b;
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    // R1 reset state
    chk("R1 count", fill_count, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 rd_data", rd_data, 0);
    fifo_enable = 1'b1;

    // Table walk: R2 selection and length, R3 order, R5 empty read, R9 clear
    for (int v = 0; v < 8; v++) begin
      logic [15:0] t, x, y, z;
      t = 16'h1100 + 16'(v); x = 16'h2A00 + 16'(v);
      y = 16'h3C00 + 16'(v); z = 16'h4E00 + 16'(v);
      cap_en = VEC[v][15:8];
      sample(t, x, y, z);
      chk("R2 length", fill_count, int'(VEC[v][7:0]));
      build(cap_en, 0, t, x, y, z);
      drain_expect("R3 byte order", 0);
      read_byte(b);
      chk("R5 empty data", b, 0);
      chk("R5 empty count", fill_count, 0);
      clear();
    end

    // R6 footer: none before first read, present after
    cap_en = 8'hF1;
    sample(16'hA1A2, 16'hB1B2, 16'hC1C2, 16'hD1D2);
    chk("R6 no footer before read", fill_count, 8);
    read_byte(b);
    chk("R4 oldest byte", b, 8'hA1);
    chk("R4 count drop", fill_count, 7);
    sample(16'hE1E2, 16'hF1F2, 16'h1112, 16'h2122);
    chk("R6 footer added", fill_count, 17);
    build(8'hF0, 0, 16'hA1A2, 16'hB1B2, 16'hC1C2, 16'hD1D2);
    drain_expect("R6 first sample", 1);
    build(8'hF0, 1, 16'hE1E2, 16'hF1F2, 16'h1112, 16'h2122);
    drain_expect("R6 footer then sample", 0);
    // R9 clear forgets the footer state
    clear();
    sample(16'h0102, 16'h0304, 16'h0506, 16'h0708);
    chk("R9 footer state cleared", fill_count, 8);
    clear();

    // R6 footer mode off
    cap_en = 8'hF0;
    sample(16'h1, 16'h2, 16'h3, 16'h4);
    read_byte(b);
    sample(16'h1, 16'h2, 16'h3, 16'h4);
    chk("R6 no footer when off", fill_count, 15);
    clear();

    // R11 back-to-back strobes
    @(negedge clk);
    sample_strobe = 1'b1;
    cycles(2);
    sample_strobe = 1'b0;
    cycles(12);
    chk("R11 busy strobe ignored", fill_count, 8);
    clear();

    // R10 capture disabled, reads still work
    sample(16'h55AA, 16'h1, 16'h2, 16'h3);
    fifo_enable = 1'b0;
    sample(16'h9999, 16'h1, 16'h2, 16'h3);
    chk("R10 strobe ignored", fill_count, 8);
    read_byte(b);
    chk("R10 read while disabled", b, 8'h55);
    fifo_enable = 1'b1;
    clear();

    // R7 / R8 overflow
    for (int s = 0; s < 63; s++) sample(16'(s), 16'h1, 16'h2, 16'h3);
    chk("R8 not yet full", ovf_flag, 0);
    chk("R7 count 504", fill_count, 504);
    sample(16'h7777, 16'h1, 16'h2, 16'h3);
    chk("R7 count full", fill_count, 16'h0200);
    chk("R8 flag at full", ovf_flag, 1);
    sample(16'h8888, 16'h1, 16'h2, 16'h3);
    chk("R7 saturate", fill_count, 512);
    read_byte(b);
    chk("R7 oldest kept", b, 8'h00);
    chk("R8 sticky after read", ovf_flag, 1);
    chk("R4 count after read", fill_count, 511);
    clear();
    chk("R9 count cleared", fill_count, 0);
    chk("R9 ovf cleared", ovf_flag, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule